// File: doc/BRIEF.md
# Two-Thread Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken, for an in-order core that runs two hardware threads. Each thread keeps its own shift register of recent branch outcomes. A lookup forms a table index by XORing the requesting thread's history with the word-address bits of the fetch PC. That index selects a 2-bit saturating counter, and the counter's upper half of values means "taken". The lookup path is purely combinational: the prediction and the index appear in the same cycle as the thread ID and PC.

When the branch resolves, the core returns the thread ID, the index that the lookup reported, and the real outcome. The block then moves that counter one step toward the outcome and shifts the outcome into the thread's history. Because the update uses the index captured at lookup time, later history shifts cannot redirect training to the wrong counter.

After reset, a clear sequence writes the weakly-not-taken value into one counter per cycle. Until the sequence finishes, `ready` stays low, predictions read not-taken, and updates are dropped.

Top module: `dirpred_gshare`

## Requirements
- R1: `lk_idx` equals the history of thread `lk_tid` XOR `lk_pc[PC_LSB +: HIST_W]` (default bits [13:2]), in the same cycle as the lookup inputs.
- R2: `lk_taken` is 1 exactly when the addressed counter holds 2 or 3, and 0 when it holds 0 or 1.
- R3: An accepted update with `up_taken`=1 adds one to the counter, stopping at 3. With `up_taken`=0 it subtracts one, stopping at 0.
- R4: An accepted update sets the thread's history to (old << 1) | `up_taken`, with taken encoded as 1 and not-taken as 0. The oldest bit is discarded. The new value is visible to lookups from the next cycle.
- R5: Each thread's history changes only on updates that carry its own thread ID.
- R6: Reset clears both histories to zero. The clear sequence then sets every counter to 1, one per cycle. `ready` rises exactly 2^HIST_W cycles after reset is released and stays high.
- R7: While `ready` is low, `lk_taken` is 0, and `up_valid` changes neither the counters nor the histories.
- R8: When a lookup and an update touch the same counter in the same cycle, the lookup returns the prediction from before the update.
- R9: An update trains the counter named by `up_idx`, whatever the thread's current history is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_tid | input | TID_W | Thread making the lookup |
| lk_pc | input | PC_W | Fetch address of the branch |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_idx | output | HIST_W | Counter index used for this lookup |
| up_valid | input | 1 | Resolved branch update present |
| up_tid | input | TID_W | Thread whose history is shifted |
| up_idx | input | HIST_W | Index reported at lookup time |
| up_taken | input | 1 | Resolved outcome, 1 = taken |
| ready | output | 1 | Counter clear sequence finished |

## Verification
The bench builds the block with HIST_W = 4, two threads and a 32-bit PC. With these values the table has 16 counters, so the clear sequence takes 16 cycles and its exact length can be checked. Index aliasing between the two threads and between different PCs also becomes easy to set up. In a short run, both saturation limits of a counter are reached, and history bits visibly fall off the top of the 4-bit register. The same-cycle collision and the stale-index update are each set up on a counter whose state is known.

// File: rtl/dirpred_pkg.sv
package dirpred_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_WEAK_NT = 2'd1;

    // saturating step toward the resolved outcome
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        nxt = cur;
        if (taken && cur != 2'd3) begin
            nxt = cur + 2'd1;
        end else if (!taken && cur != 2'd0) begin
            nxt = cur - 2'd1;
        end
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/dirpred_hist.sv
module dirpred_hist #(
    parameter int HIST_W  = 12,
    parameter int THREADS = 2,
    localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [TID_W-1:0]  upd_tid,
    input  logic              upd_taken,
    input  logic [TID_W-1:0]  rd_tid,
    output logic [HIST_W-1:0] rd_hist
);

    typedef struct packed {
        logic [THREADS-1:0][HIST_W-1:0] hist;
    } hist_state_t;

    hist_state_t state_q, state_d;
    logic [THREADS-1:0][HIST_W-1:0] shifted;

    // one shift path per hardware thread
    for (genvar t = 0; t < THREADS; t++) begin : g_thread
        assign shifted[t] = {state_q.hist[t][HIST_W-2:0], upd_taken};
    end

    always_comb begin
        state_d = state_q;
        for (int t = 0; t < THREADS; t++) begin
            if (upd_en && upd_tid == TID_W'(t)) begin
                state_d.hist[t] = shifted[t];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_hist = state_q.hist[rd_tid];

endmodule

// File: rtl/dirpred_table.sv
module dirpred_table
    import dirpred_pkg::*;
#(
    parameter int HIST_W = 12,
    localparam int DEPTH = 1 << HIST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HIST_W-1:0] rd_idx,
    output ctr_t              rd_ctr,
    input  logic              wr_en,
    input  logic [HIST_W-1:0] wr_idx,
    input  logic              wr_taken,
    output logic              ready
);

    typedef struct packed {
        logic [HIST_W-1:0] ptr;
        logic              busy;
    } clr_state_t;

    clr_state_t state_q, state_d;

    ctr_t              mem_q [DEPTH];
    logic              mem_we;
    logic [HIST_W-1:0] mem_addr;
    ctr_t              mem_wdata;

    always_comb begin
        state_d   = state_q;
        mem_we    = 1'b0;
        mem_addr  = wr_idx;
        mem_wdata = ctr_step(mem_q[wr_idx], wr_taken);
        if (state_q.busy) begin
            mem_we    = 1'b1;
            mem_addr  = state_q.ptr;
            mem_wdata = CTR_WEAK_NT;
            state_d.ptr = state_q.ptr + 1'b1;
            if (state_q.ptr == HIST_W'(DEPTH - 1)) begin
                state_d.busy = 1'b0;
            end
        end else if (wr_en) begin
            mem_we = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{ptr: '0, busy: 1'b1};
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (mem_we) begin
            mem_q[mem_addr] <= mem_wdata;
        end
    end

    assign rd_ctr = mem_q[rd_idx];
    assign ready  = !state_q.busy;

endmodule

// File: rtl/dirpred_gshare.sv
module dirpred_gshare
    import dirpred_pkg::*;
#(
    parameter int HIST_W  = 12,
    parameter int THREADS = 2,
    parameter int PC_W    = 32,
    parameter int PC_LSB  = 2,
    localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TID_W-1:0]  lk_tid,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              lk_taken,
    output logic [HIST_W-1:0] lk_idx,
    input  logic              up_valid,
    input  logic [TID_W-1:0]  up_tid,
    input  logic [HIST_W-1:0] up_idx,
    input  logic              up_taken,
    output logic              ready
);

    logic [HIST_W-1:0] cur_hist;
    ctr_t              cur_ctr;
    logic              upd_ok;
    logic              unused_pc_bits;

    assign unused_pc_bits = ^{lk_pc[PC_W-1:PC_LSB+HIST_W], lk_pc[PC_LSB-1:0]};
    assign upd_ok         = up_valid && ready;

    dirpred_hist #(
        .HIST_W  (HIST_W),
        .THREADS (THREADS)
    ) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (upd_ok),
        .upd_tid   (up_tid),
        .upd_taken (up_taken),
        .rd_tid    (lk_tid),
        .rd_hist   (cur_hist)
    );

    assign lk_idx = cur_hist ^ lk_pc[PC_LSB +: HIST_W];

    dirpred_table #(
        .HIST_W (HIST_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_ctr   (cur_ctr),
        .wr_en    (upd_ok),
        .wr_idx   (up_idx),
        .wr_taken (up_taken),
        .ready    (ready)
    );

    assign lk_taken = ready && ctr_says_taken(cur_ctr);

endmodule

// File: rtl/dirpred_gshare_chk.sv
module dirpred_gshare_chk #(
    parameter int HIST_W  = 12,
    parameter int PC_W    = 32,
    parameter int PC_LSB  = 2,
    parameter int TID_W   = 1,
    localparam int DEPTH  = 1 << HIST_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TID_W-1:0]  lk_tid,
    input logic [PC_W-1:0]   lk_pc,
    input logic              lk_taken,
    input logic [HIST_W-1:0] lk_idx,
    input logic              up_valid,
    input logic [TID_W-1:0]  up_tid,
    input logic              up_taken,
    input logic              ready
);

    logic [HIST_W-1:0] pcb;
    logic [HIST_W:0]   since_rst;
    logic              own_upd;
    logic              unused_chk_pc;

    assign pcb           = lk_pc[PC_LSB +: HIST_W];
    assign unused_chk_pc = ^{lk_pc[PC_W-1:PC_LSB+HIST_W], lk_pc[PC_LSB-1:0]};
    assign own_upd       = up_valid && ready && (up_tid == lk_tid);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != (HIST_W+1)'(DEPTH)) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    // R6: clear takes exactly DEPTH cycles, and ready never drops again
    p_ready_timing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready == (since_rst == (HIST_W+1)'(DEPTH)));

    p_ready_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R7: no taken prediction before the table is cleared
    p_quiet_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !lk_taken);

    // R7: history remains zero while clearing, so the index is the PC bits alone
    p_hist_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> lk_idx == pcb);

    // R4: accepted update shifts the outcome into the looked-up thread
    p_hist_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(own_upd) && $stable(lk_tid) && $stable(lk_pc) |->
        lk_idx == (HIST_W'({$past(lk_idx ^ pcb), $past(up_taken)}) ^ pcb));

    // R5: without an update for this thread, its history holds
    p_hist_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!own_upd) && $stable(lk_tid) && $stable(lk_pc) |-> $stable(lk_idx));

endmodule

bind dirpred_gshare dirpred_gshare_chk #(
    .HIST_W (HIST_W),
    .PC_W   (PC_W),
    .PC_LSB (PC_LSB),
    .TID_W  (TID_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_tid   (lk_tid),
    .lk_pc    (lk_pc),
    .lk_taken (lk_taken),
    .lk_idx   (lk_idx),
    .up_valid (up_valid),
    .up_tid   (up_tid),
    .up_taken (up_taken),
    .ready    (ready)
);

// File: tb/dirpred_gshare_tb_top.sv
`timescale 1ns/1ps
module dirpred_gshare_tb_top;

    localparam int HW    = 4;
    localparam int DEPTH = 1 << HW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [0:0]    lk_tid = '0;
    logic [31:0]   lk_pc = '0;
    logic          lk_taken;
    logic [HW-1:0] lk_idx;
    logic          up_valid = 1'b0;
    logic [0:0]    up_tid = '0;
    logic [HW-1:0] up_idx = '0;
    logic          up_taken = 1'b0;
    logic          ready;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    dirpred_gshare #(
        .HIST_W (HW), .THREADS (2), .PC_W (32), .PC_LSB (2)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .lk_tid (lk_tid), .lk_pc (lk_pc), .lk_taken (lk_taken), .lk_idx (lk_idx),
        .up_valid (up_valid), .up_tid (up_tid), .up_idx (up_idx), .up_taken (up_taken),
        .ready (ready)
    );

    // {tid, pc[7:0], outcome, expected prediction, expected index}
    localparam int NV = 12;
    localparam logic [14:0] VEC [NV] = '{
        {1'b0, 8'h14, 1'b1, 1'b0, 4'd5},   // R1 fresh history
        {1'b0, 8'h14, 1'b1, 1'b0, 4'd4},   // R4 history now 0001
        {1'b1, 8'h14, 1'b0, 1'b1, 4'd5},   // R5 thread 1 still zero, R3 ctr 2
        {1'b0, 8'h0C, 1'b0, 1'b0, 4'd0},
        {1'b0, 8'h18, 1'b0, 1'b0, 4'd0},   // R3 floor at 0
        {1'b1, 8'h10, 1'b1, 1'b1, 4'd4},
        {1'b1, 8'h14, 1'b1, 1'b1, 4'd4},   // R3 ceiling at 3
        {1'b0, 8'h30, 1'b1, 1'b0, 4'd0},   // R4 oldest bit dropped next
        {1'b0, 8'h24, 1'b1, 1'b0, 4'd0},
        {1'b1, 8'h1C, 1'b0, 1'b1, 4'd4},
        {1'b0, 8'h70, 1'b1, 1'b0, 4'd15},  // R1 PC bit 6 outside the index
        {1'b0, 8'h00, 1'b0, 1'b0, 4'd7}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic lookup(input logic tid, input logic [31:0] pc);
        @(negedge clk);
        lk_tid = tid;
        lk_pc  = pc;
        #1;
    endtask

    task automatic update(input logic tid, input logic [HW-1:0] idx, input logic tk);
        @(negedge clk);
        up_valid = 1'b1; up_tid = tid; up_idx = idx; up_taken = tk;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
                finish_run();
            end
        end
    end

    initial begin
        int waited;
        logic [HW-1:0] got_idx;
        do_reset();
        #1;
        check(ready == 1'b0, "R6 ready after reset", ready, 0);
        check(lk_taken == 1'b0, "R7 taken while clearing", lk_taken, 0);
        check(lk_idx == 4'd0, "R6 history zero", lk_idx, 0);
        waited = 0;
        while (!ready && waited < 100) begin
            @(negedge clk);
            waited++;
        end
        check(waited == DEPTH, "R6 clear length", waited, DEPTH);

        for (int i = 0; i < NV; i++) begin
            lookup(VEC[i][14], {24'd0, VEC[i][13:6]});
            got_idx = lk_idx;
            check(lk_idx == VEC[i][3:0], "R1/R4/R5 index", lk_idx, VEC[i][3:0]);
            check(lk_taken == VEC[i][4], "R2/R3 prediction", lk_taken, VEC[i][4]);
            update(VEC[i][14], got_idx, VEC[i][5]);
        end

        // R8: thread 1 history 0110, pc bits 0010 -> index 4 holding 2
        lookup(1'b1, 32'h08);
        check(lk_idx == 4'd4, "R8 index", lk_idx, 4);
        up_valid = 1'b1; up_tid = 1'b1; up_idx = 4'd4; up_taken = 1'b0;
        #1;
        check(lk_taken == 1'b1, "R8 pre-update value", lk_taken, 1);
        @(negedge clk);
        up_valid = 1'b0;
        // history now 1100; pc bits 1000 -> index 4, counter now 1
        lookup(1'b1, 32'h20);
        check(lk_idx == 4'd4, "R4 index after collision", lk_idx, 4);
        check(lk_taken == 1'b0, "R8 trained after edge", lk_taken, 0);

        // R9: two updates on index 9 while history moves 1110 -> 1011
        update(1'b0, 4'd9, 1'b1);
        update(1'b0, 4'd9, 1'b1);
        lookup(1'b0, 32'h08);
        check(lk_idx == 4'd9, "R9 index", lk_idx, 9);
        check(lk_taken == 1'b1, "R9 stored index trained", lk_taken, 1);

        // R7: updates during the clear are dropped
        do_reset();
        update(1'b0, 4'd2, 1'b1);
        lookup(1'b0, 32'h00);
        check(ready == 1'b0, "R7 still clearing", ready, 0);
        check(lk_idx == 4'd0, "R7 history untouched during clear", lk_idx, 0);
        waited = 0;
        while (!ready && waited < 100) begin
            @(negedge clk);
            waited++;
        end
        lookup(1'b0, 32'h00);
        check(lk_idx == 4'd0, "R7 history after clear", lk_idx, 0);
        check(lk_taken == 1'b0, "R6 counter back to weak not-taken", lk_taken, 0);
        lookup(1'b1, 32'h14);
        check(lk_taken == 1'b0, "R6 cleared entry 5", lk_taken, 0);

        finish_run();
    end

endmodule